// File: doc/BRIEF.md
# Programmable Interrupt Routing Collector

This block gathers interrupt requests that arrive from outside a processor core, such as level-sensitive peripheral lines and software-raised requests, and steers each one to exactly one of six outputs: four interrupt lines into the core and two interrupt pins on the host bus. Every source has its own route code and its own enable bit. Every output has its own enable bit. A single global enable bit gates everything aimed at the core. No source outranks another. Each output is simply the OR of the live requests steered to it, and software chooses the order of service.

Software programs the block through a small word-addressed register port with a write strobe and a combinational read path. It can read back every setting and the raw pending state of all sources. It raises or drops software requests through a write-one-to-set word and a write-one-to-clear word. Hardware request levels are sampled once per clock, and the outputs are registered.

Top module: `irq_route_collector`

## Requirements
- R1: After reset, all six outputs are low, the source enables, target enables, global enable and software pending bits read 0, and every route field reads 7 (unrouted).
- R2: A source's 3-bit route field (word 32+k for source k, bits 2:0) selects its output: codes 0 to 3 drive core_irq bit 0 to 3, codes 4 and 5 drive host_irq bit 0 and 1, and codes 6 and 7 drive nothing.
- R3: Each output is the OR of every source that is pending, has its enable bit set (word 0, bit k), and is routed to it. There is no priority, so an output stays high while any one of its sources is still live.
- R4: Target enable word 1 holds one bit per output: bits 0 to 3 for the core lines and bits 4 and 5 for the host pins. A cleared bit forces that output low.
- R5: Global enable (word 2, bit 0) cleared forces all core lines low and leaves the host pins unaffected.
- R6: Software sources occupy indices N_HW upward. Writing word 4 sets the software pending bits written as 1, and writing word 5 clears the bits written as 1. Zero bits in either write leave their pending bits unchanged. Reading word 4 returns the software pending bits.
- R7: Reading word 3 returns the raw pending state, with hardware levels in bits N_HW-1:0 and software pending bits above them, whatever the enables. Configuration words read back the value last written.
- R8: A change on hw_irq or a register write reaches the outputs on the second rising clock edge after it is presented, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_irq | input | N_HW | Level-sensitive hardware request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| core_irq | output | 4 | Interrupt lines into the core |
| host_irq | output | 2 | Interrupt pins on the host bus |

## Verification
The hardest case to reach is an output whose several routed sources drop away one at a time while the target enables and the global enable keep changing, because only then is the missing priority logic and the OR behaviour exposed. The stimulus reaches it in two ways. Directed sequences steer two sources to one pin and remove them one by one. A long seeded random run mixes route rewrites, enable flips, software set/clear writes and hardware level changes, so that many sources share targets. After every step the outputs and the pending word are compared with a bench model.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ROUTE_W = 3;
  localparam int unsigned N_CORE  = 4;
  localparam int unsigned N_HOST  = 2;
  localparam int unsigned N_TGT   = N_CORE + N_HOST;

  typedef logic [ROUTE_W-1:0] route_t;
  localparam route_t ROUTE_NONE = route_t'(7);

  // register word offsets
  localparam int unsigned OFS_SRC_EN = 0;
  localparam int unsigned OFS_TGT_EN = 1;
  localparam int unsigned OFS_CTRL   = 2;
  localparam int unsigned OFS_PEND   = 3;
  localparam int unsigned OFS_SW_SET = 4;
  localparam int unsigned OFS_SW_CLR = 5;
  localparam int unsigned OFS_ROUTE  = 32;
endpackage

// File: rtl/irc_rst_sync.sv
module irc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int unsigned N_HW   = 12,
  parameter int unsigned N_SW   = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_HW-1:0]               hw_irq,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [N_HW+N_SW-1:0]          src_pend,
  output logic [N_HW+N_SW-1:0]          src_en,
  output route_t [N_HW+N_SW-1:0]        src_route,
  output logic [N_TGT-1:0]              tgt_en,
  output logic                          glob_en
);
  localparam int unsigned N_SRC = N_HW + N_SW;

  logic [N_HW-1:0]    hw_lvl_q;
  logic [N_SW-1:0]    sw_q, sw_d;
  logic [N_SRC-1:0]   en_q, en_d;
  route_t [N_SRC-1:0] route_q, route_d;
  logic [N_TGT-1:0]   tgt_q, tgt_d;
  logic               glob_q, glob_d;

  logic               we_en, we_tgt, we_ctl, we_set, we_clr;
  logic [N_SRC-1:0]   we_route;
  logic               unused_wbits;

  assign unused_wbits = ^wdata;

  // write decode
  always_comb begin
    we_en  = wr && (addr == ADDR_W'(OFS_SRC_EN));
    we_tgt = wr && (addr == ADDR_W'(OFS_TGT_EN));
    we_ctl = wr && (addr == ADDR_W'(OFS_CTRL));
    we_set = wr && (addr == ADDR_W'(OFS_SW_SET));
    we_clr = wr && (addr == ADDR_W'(OFS_SW_CLR));
    for (int k = 0; k < N_SRC; k++) begin
      we_route[k] = wr && (addr == ADDR_W'(OFS_ROUTE + k));
    end
  end

  // next state
  always_comb begin
    en_d   = we_en  ? wdata[N_SRC-1:0] : en_q;
    tgt_d  = we_tgt ? wdata[N_TGT-1:0] : tgt_q;
    glob_d = we_ctl ? wdata[0]         : glob_q;
    sw_d   = sw_q;
    if (we_set) sw_d = sw_d | wdata[N_SW-1:0];
    if (we_clr) sw_d = sw_d & ~wdata[N_SW-1:0];
    for (int k = 0; k < N_SRC; k++) begin
      route_d[k] = we_route[k] ? wdata[ROUTE_W-1:0] : route_q[k];
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_lvl_q <= '0;
      sw_q     <= '0;
      en_q     <= '0;
      tgt_q    <= '0;
      glob_q   <= 1'b0;
      route_q  <= {N_SRC{ROUTE_NONE}};
    end else begin
      hw_lvl_q <= hw_irq;
      if (we_set || we_clr) sw_q <= sw_d;
      if (we_en)            en_q <= en_d;
      if (we_tgt)           tgt_q <= tgt_d;
      if (we_ctl)           glob_q <= glob_d;
      if (|we_route)        route_q <= route_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_SRC_EN)) rdata[N_SRC-1:0] = en_q;
    if (addr == ADDR_W'(OFS_TGT_EN)) rdata[N_TGT-1:0] = tgt_q;
    if (addr == ADDR_W'(OFS_CTRL))   rdata[0]         = glob_q;
    if (addr == ADDR_W'(OFS_PEND))   rdata[N_SRC-1:0] = {sw_q, hw_lvl_q};
    if (addr == ADDR_W'(OFS_SW_SET)) rdata[N_SW-1:0]  = sw_q;
    for (int k = 0; k < N_SRC; k++) begin
      if (addr == ADDR_W'(OFS_ROUTE + k)) rdata[ROUTE_W-1:0] = route_q[k];
    end
  end

  assign src_pend  = {sw_q, hw_lvl_q};
  assign src_en    = en_q;
  assign src_route = route_q;
  assign tgt_en    = tgt_q;
  assign glob_en   = glob_q;

  logic alive_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive_q <= 1'b0;
    else        alive_q <= 1'b1;
  end

  // R6: bits written as 1 to the set word are pending afterwards
  assert_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alive_q && $past(wr && addr == ADDR_W'(OFS_SW_SET))
      |-> ((sw_q & $past(wdata[N_SW-1:0])) == $past(wdata[N_SW-1:0])));

  // R6: bits written as 1 to the clear word are gone afterwards
  assert_sw_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alive_q && $past(wr && addr == ADDR_W'(OFS_SW_CLR))
      |-> ((sw_q & $past(wdata[N_SW-1:0])) == '0));

  // R6: software pending holds when neither word is written
  assert_sw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alive_q && !$past(wr && (addr == ADDR_W'(OFS_SW_SET) || addr == ADDR_W'(OFS_SW_CLR)))
      |-> $stable(sw_q));
endmodule

// File: rtl/irc_route.sv
module irc_route
  import irc_pkg::*;
#(
  parameter int unsigned N_SRC = 16
) (
  input  logic [N_SRC-1:0]   src_pend,
  input  logic [N_SRC-1:0]   src_en,
  input  route_t [N_SRC-1:0] src_route,
  output logic [N_TGT-1:0]   tgt_hit
);
  logic [N_TGT-1:0][N_SRC-1:0] sel_t;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic live;
    assign live = src_pend[s] & src_en[s];
    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
      assign sel_t[t][s] = live && (src_route[s] == route_t'(t));
    end
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_or
    assign tgt_hit[t] = |sel_t[t];
  end
endmodule

// File: rtl/irc_gate.sv
module irc_gate
  import irc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TGT-1:0]  tgt_hit,
  input  logic [N_TGT-1:0]  tgt_en,
  input  logic              glob_en,
  output logic [N_CORE-1:0] core_irq,
  output logic [N_HOST-1:0] host_irq
);
  logic [N_TGT-1:0] allow, out_d, out_q;

  for (genvar t = 0; t < N_TGT; t++) begin : g_allow
    if (t < N_CORE) begin : g_core
      assign allow[t] = tgt_en[t] & glob_en;
    end else begin : g_host
      assign allow[t] = tgt_en[t];
    end
  end

  always_comb begin
    out_d = tgt_hit & allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign core_irq = out_q[N_CORE-1:0];
  assign host_irq = out_q[N_TGT-1:N_CORE];

  logic alive_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive_q <= 1'b0;
    else        alive_q <= 1'b1;
  end

  // R5: global enable off keeps every core line low
  assert_core_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alive_q && !$past(glob_en) |-> (core_irq == '0));

  for (genvar t = 0; t < N_TGT; t++) begin : g_chk
    // R4: a cleared target enable keeps its output low
    assert_tgt_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alive_q && !$past(tgt_en[t]) |-> !out_q[t]);
    // R3: an output rises only when some live source is routed to it
    assert_out_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alive_q && out_q[t] |-> $past(tgt_hit[t]));
  end
endmodule

// File: rtl/irq_route_collector.sv
module irq_route_collector
  import irc_pkg::*;
#(
  parameter int unsigned N_HW   = 12,
  parameter int unsigned N_SW   = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [3:0]        core_irq,
  output logic [1:0]        host_irq
);
  localparam int unsigned N_SRC = N_HW + N_SW;

  logic               rst_int_n;
  logic [N_SRC-1:0]   src_pend, src_en;
  route_t [N_SRC-1:0] src_route;
  logic [N_TGT-1:0]   tgt_en, tgt_hit;
  logic               glob_en;

  irc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irc_regs #(.N_HW(N_HW), .N_SW(N_SW), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hw_irq    (hw_irq),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .src_pend  (src_pend),
    .src_en    (src_en),
    .src_route (src_route),
    .tgt_en    (tgt_en),
    .glob_en   (glob_en)
  );

  irc_route #(.N_SRC(N_SRC)) u_route (
    .src_pend  (src_pend),
    .src_en    (src_en),
    .src_route (src_route),
    .tgt_hit   (tgt_hit)
  );

  irc_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tgt_hit  (tgt_hit),
    .tgt_en   (tgt_en),
    .glob_en  (glob_en),
    .core_irq (core_irq),
    .host_irq (host_irq)
  );
endmodule

// File: tb/irq_route_collector_tb.sv
`timescale 1ns/1ps
module irq_route_collector_tb;
  localparam int N_HW = 12;
  localparam int N_SW = 4;
  localparam int N_SRC = N_HW + N_SW;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N_HW-1:0]   hw_irq;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [3:0]        core_irq;
  logic [1:0]        host_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model
  logic [N_SRC-1:0] m_en;
  logic [5:0]       m_tgt;
  logic             m_glob;
  logic [2:0]       m_route [N_SRC];
  logic [N_SW-1:0]  m_sw;

  irq_route_collector #(.N_HW(N_HW), .N_SW(N_SW), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_irq(core_irq), .host_irq(host_irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [5:0] model_out();
    logic [5:0] r = '0;
    logic [N_SRC-1:0] pend = {m_sw, hw_irq};
    for (int k = 0; k < N_SRC; k++)
      if (pend[k] && m_en[k] && m_route[k] < 3'd6) r[m_route[k]] = 1'b1;
    r = r & m_tgt;
    if (!m_glob) r[3:0] = 4'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 0) m_en = d[N_SRC-1:0];
    else if (a == 1) m_tgt = d[5:0];
    else if (a == 2) m_glob = d[0];
    else if (a == 4) m_sw = m_sw | d[N_SW-1:0];
    else if (a == 5) m_sw = m_sw & ~d[N_SW-1:0];
    else if (a >= 32 && a < 32 + N_SRC) m_route[a-32] = d[2:0];
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    reg_addr = ADDR_W'(a);
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic out_chk(input string tag);
    chk(tag, {26'b0, host_irq, core_irq}, {26'b0, model_out()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; hw_irq = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_en = '0; m_tgt = '0; m_glob = 1'b0; m_sw = '0;
    for (int k = 0; k < N_SRC; k++) m_route[k] = 3'd7;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outputs in reset", {26'b0, host_irq, core_irq}, 32'h0);
    rd_chk("R1 route reset", 32 + 5, 32'h7);
    rd_chk("R1 src enable reset", 0, 32'h0);
    rst_n = 1'b1;
    hw_irq = '1;
    repeat (4) @(negedge clk);
    chk("R1 outputs after reset", {26'b0, host_irq, core_irq}, 32'h0);
    rd_chk("R1 ctrl reset", 2, 32'h0);
    rd_chk("R1 sw pending reset", 4, 32'h0);
    // R7: raw pending regardless of enables
    rd_chk("R7 raw pending", 3, {16'b0, m_sw, hw_irq});
    hw_irq = '0;

    // R2: every route code for source 3
    wr_reg(0, 32'h0008); wr_reg(1, 32'h3F); wr_reg(2, 32'h1);
    hw_irq[3] = 1'b1;
    for (int c = 0; c < 8; c++) begin
      wr_reg(32 + 3, c);
      settle();
      chk("R2 route code decode", {26'b0, host_irq, core_irq},
          (c < 6) ? (32'h1 << c) : 32'h0);
      rd_chk("R7 route readback", 32 + 3, c);
    end
    hw_irq = '0;

    // R8: latency from a hardware level
    wr_reg(0, 32'h0001); wr_reg(32 + 0, 1);
    settle();
    hw_irq[0] = 1'b1;
    @(negedge clk);
    chk("R8 not yet after first edge", {28'b0, core_irq}, 32'h0);
    @(negedge clk);
    chk("R8 visible after second edge", {28'b0, core_irq}, 32'h2);
    hw_irq = '0;

    // R3: two sources on host pin 0, no priority
    wr_reg(0, 32'h0006); wr_reg(32 + 1, 4); wr_reg(32 + 2, 4);
    hw_irq[1] = 1'b1; hw_irq[2] = 1'b1; settle();
    chk("R3 two sources", {30'b0, host_irq}, 32'h1);
    hw_irq[1] = 1'b0; settle();
    chk("R3 one source left", {30'b0, host_irq}, 32'h1);
    hw_irq[2] = 1'b0; settle();
    chk("R3 none left", {30'b0, host_irq}, 32'h0);

    // R4: target mask
    hw_irq[1] = 1'b1; wr_reg(1, 32'h2F); settle();
    chk("R4 host0 masked", {30'b0, host_irq}, 32'h0);
    wr_reg(1, 32'h3F); settle();
    chk("R4 host0 unmasked", {30'b0, host_irq}, 32'h1);

    // R5: global enable core only
    wr_reg(0, 32'h000F); wr_reg(32 + 0, 2); hw_irq[0] = 1'b1;
    wr_reg(2, 32'h0); settle();
    chk("R5 core gated", {28'b0, core_irq}, 32'h0);
    chk("R5 host unaffected", {30'b0, host_irq}, 32'h1);
    wr_reg(2, 32'h1); settle();
    chk("R5 core restored", {28'b0, core_irq}, 32'h4);
    hw_irq = '0;

    // R6: software set / clear
    wr_reg(0, 32'h1 << N_HW); wr_reg(32 + N_HW, 5);
    wr_reg(4, 32'h0); settle();
    rd_chk("R6 zero set ignored", 4, 32'h0);
    wr_reg(4, 32'h5); settle();
    rd_chk("R6 set bits", 4, 32'h5);
    chk("R6 sw drives host1", {30'b0, host_irq}, 32'h2);
    wr_reg(5, 32'h0); settle();
    rd_chk("R6 zero clear ignored", 4, 32'h5);
    wr_reg(5, 32'h1); settle();
    rd_chk("R6 clear bit", 4, 32'h4);
    chk("R6 host1 dropped", {30'b0, host_irq}, 32'h0);
    rd_chk("R7 pending shows sw", 3, {16'b0, m_sw, hw_irq});

    // random mix, R3 against model
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: wr_reg(0, $urandom);
        1: wr_reg(1, $urandom);
        2: wr_reg(2, $urandom);
        3: wr_reg(32 + $urandom_range(0, N_SRC - 1), $urandom);
        4: wr_reg(4, $urandom);
        5: wr_reg(5, $urandom);
        default: hw_irq = N_HW'($urandom);
      endcase
      settle();
      out_chk("R3 random outputs");
      rd_chk("R7 random pending", 3, {16'b0, m_sw, hw_irq});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule